// File: doc/BRIEF.md
# Interrupt Pin Redirection Controller

This block turns activity on a bank of interrupt input pins into interrupt messages, one at a time. Each pin has its own 64-bit routing entry. Software reads and writes the entry as two 32-bit words through a small register port. The entry sets the pin's polarity, its trigger mode (edge or level), its mask, the vector to send, and the destination (a target ID or a logical destination set).

Each pin has a small delivery state machine. Once the pin's condition is seen, it records a pending delivery and ignores further activity until the outgoing message is acknowledged. Pending pins compete for the single message output, and the lowest-numbered pin wins. The message is held valid until `msg_ack`.

For level-triggered pins, an acknowledge also sets a remote-request flag. That flag blocks redelivery until an end-of-interrupt carrying the entry's vector comes back. If the level is still asserted at that point, the pin requests again.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, `msg_valid` is 0. Every entry's low word reads 0x0001_0000, which means masked, with all other fields 0. Every entry's high word reads 0.
- R2: Entry i's low word is at register index 0x10+2i and its high word is at 0x11+2i. The writable fields read back as written:
  - low bits 7:0 are the vector;
  - low bit 11 is the destination mode (1 = logical);
  - low bit 13 is the polarity (1 = active low);
  - low bit 15 is the trigger mode (1 = level);
  - low bit 16 is the mask;
  - high bits 31:24 are the destination.
  
  Indices outside 0x10..0x3F read 0 and writes to them change nothing. A register read returns data one cycle after the index is presented.
- R3: Writes to low bit 12 (delivery status), low bit 14 (remote flag), low bits 10:8, and high bits 23:0 have no effect, and those bits read as the state they hold.
- R4: For an unmasked edge-mode pin, a rising active edge makes `msg_valid` rise two clock edges later. The message carries the pin index, the vector, the destination, the destination mode and `msg_level`=0.
- R5: With polarity set to active low, the pin is inverted before detection. Its falling raw edge is the active edge, and a rising raw edge starts nothing.
- R6: While a pin's delivery is pending, new edges on that pin are ignored. One edge sequence gives exactly one message.
- R7: A masked pin raises no message. If a pin is masked while pending and is not the message being presented, its pending delivery is dropped.
- R8: A level-mode pin that is asserted, unmasked, not pending and has its remote flag clear raises a message with `msg_level`=1. Its acknowledge sets the remote flag (low bit 14), and no redelivery happens while that flag is set.
- R9: An end-of-interrupt whose vector equals a level entry's vector clears that entry's remote flag. If the level is still asserted, the pin is redelivered. An end-of-interrupt with a different vector has no effect.
- R10: When several pins are pending, the lowest-numbered pin is presented first. The presented message stays valid and unchanged until acknowledged.
- R11: Delivery status (low bit 12) reads 1 while a pin's message is pending and 0 after its acknowledge. `msg_valid` drops at the acknowledge edge, and the next pending message appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_PINS | Raw interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the index of the previous cycle |
| msg_valid | output | 1 | Outgoing message valid |
| msg_pin | output | IDX_W | Index of the pin being delivered |
| msg_vector | output | 8 | Vector of the message |
| msg_dest | output | 8 | Destination field of the message |
| msg_dest_logical | output | 1 | Destination mode of the message (1 = logical) |
| msg_level | output | 1 | Message comes from a level-mode pin |
| msg_ack | input | 1 | Far end accepted the presented message |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |

## Verification
Each result has a fixed latency:
- Register read data is due one edge after the index is set.
- A pin's active edge or level reaches `msg_valid` two edges later: one edge to record the pending delivery, one to load the output register.
- An acknowledge drops `msg_valid` at its own edge, and the next pending message appears one edge after that.
- An end-of-interrupt on an asserted level pin gives a new message three edges after it: clear the flag, record pending, then load the output.

The bench drives inputs just after a rising edge and samples one nanosecond later. It steps the exact number of edges for each result and checks both the cycle before and the cycle of the change. The "no effect" requirements are checked by reading the entry back and by watching `msg_valid` over several cycles.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Writable routing state of one pin; status bits live in the pin fronts.
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig_lvl;
    logic       act_low;
    logic       dest_logical;
    logic [7:0] vector;
  } route_cfg_t;

  localparam route_cfg_t CFG_RST = '{dest: 8'h00, mask: 1'b1, trig_lvl: 1'b0,
                                      act_low: 1'b0, dest_logical: 1'b0,
                                      vector: 8'h00};

  // Bit positions inside the low register word.
  localparam int LO_MASK   = 16;
  localparam int LO_TRIG   = 15;
  localparam int LO_ACTLOW = 13;
  localparam int LO_DMODE  = 11;

endpackage

// File: rtl/irq_pin_front.sv
module irq_pin_front (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw,
  input  logic       cfg_mask,
  input  logic       cfg_level,
  input  logic       cfg_act_low,
  input  logic [7:0] cfg_vector,
  input  logic       presented,
  input  logic       acked,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  output logic       pend,
  output logic       rirr
);

  logic act_now, act_prev, edge_hit, want, done, eoi_hit;

  assign act_now  = raw ^ cfg_act_low;
  assign edge_hit = act_now & ~act_prev;
  assign want     = cfg_level ? (act_now & ~rirr) : edge_hit;
  assign done     = presented & acked;
  assign eoi_hit  = eoi_valid & cfg_level & (eoi_vector == cfg_vector);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_prev <= 1'b0;
      pend     <= 1'b0;
      rirr     <= 1'b0;
    end else begin
      act_prev <= act_now;
      if (done)
        pend <= 1'b0;
      else if (pend && cfg_mask && !presented)
        pend <= 1'b0;
      else if (!pend && !cfg_mask && want)
        pend <= 1'b1;

      if (done && cfg_level)
        rirr <= 1'b1;
      else if (eoi_hit)
        rirr <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) idx = IDX_W'(k);
    end
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_PINS   = 24,
  parameter int ADDR_W   = 8,
  parameter int BASE_IDX = 16,
  parameter int IDX_W    = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] irq_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  output logic [IDX_W-1:0]  msg_pin,
  output logic [7:0]        msg_vector,
  output logic [7:0]        msg_dest,
  output logic              msg_dest_logical,
  output logic              msg_level,
  input  logic              msg_ack,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector
);

  localparam int LAST_IDX = BASE_IDX + 2 * N_PINS - 1;

  route_cfg_t          cfg_q [N_PINS];
  logic [N_PINS-1:0]   pend_vec, rirr_vec, mask_vec;
  logic [ADDR_W-1:0]   off;
  logic                in_range, hi_half;
  logic [IDX_W-1:0]    sel, pick_idx;
  logic                pick_any;
  logic [31:0]         rd_word;

  // Register index decode
  assign off      = reg_addr - ADDR_W'(BASE_IDX);
  assign in_range = (reg_addr >= ADDR_W'(BASE_IDX)) && (reg_addr <= ADDR_W'(LAST_IDX));
  assign hi_half  = off[0];
  assign sel      = IDX_W'(off >> 1);

  // Entry storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_PINS; i++) cfg_q[i] <= CFG_RST;
    end else if (reg_we && in_range) begin
      if (hi_half) begin
        cfg_q[sel].dest <= reg_wdata[31:24];
      end else begin
        cfg_q[sel].mask         <= reg_wdata[LO_MASK];
        cfg_q[sel].trig_lvl     <= reg_wdata[LO_TRIG];
        cfg_q[sel].act_low      <= reg_wdata[LO_ACTLOW];
        cfg_q[sel].dest_logical <= reg_wdata[LO_DMODE];
        cfg_q[sel].vector       <= reg_wdata[7:0];
      end
    end
  end

  // Registered readback
  always_comb begin
    rd_word = '0;
    if (in_range) begin
      if (hi_half)
        rd_word = {cfg_q[sel].dest, 24'h0};
      else
        rd_word = {15'h0, cfg_q[sel].mask, cfg_q[sel].trig_lvl, rirr_vec[sel],
                   cfg_q[sel].act_low, pend_vec[sel], cfg_q[sel].dest_logical,
                   3'b000, cfg_q[sel].vector};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_word;
  end

  // Per-pin detection and delivery state
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign mask_vec[g] = cfg_q[g].mask;
    irq_pin_front u_front (
      .clk        (clk),
      .rst        (rst),
      .raw        (irq_in[g]),
      .cfg_mask   (cfg_q[g].mask),
      .cfg_level  (cfg_q[g].trig_lvl),
      .cfg_act_low(cfg_q[g].act_low),
      .cfg_vector (cfg_q[g].vector),
      .presented  (msg_valid && (msg_pin == IDX_W'(g))),
      .acked      (msg_ack),
      .eoi_valid  (eoi_valid),
      .eoi_vector (eoi_vector),
      .pend       (pend_vec[g]),
      .rirr       (rirr_vec[g])
    );
  end

  // Arbitration among pending, unmasked pins
  irq_prio_pick #(.N(N_PINS), .IDX_W(IDX_W)) u_pick (
    .req(pend_vec & ~mask_vec),
    .any(pick_any),
    .idx(pick_idx)
  );

  // Outgoing message register
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid        <= 1'b0;
      msg_pin          <= '0;
      msg_vector       <= '0;
      msg_dest         <= '0;
      msg_dest_logical <= 1'b0;
      msg_level        <= 1'b0;
    end else if (msg_valid) begin
      if (msg_ack) msg_valid <= 1'b0;
    end else if (pick_any) begin
      msg_valid        <= 1'b1;
      msg_pin          <= pick_idx;
      msg_vector       <= cfg_q[pick_idx].vector;
      msg_dest         <= cfg_q[pick_idx].dest;
      msg_dest_logical <= cfg_q[pick_idx].dest_logical;
      msg_level        <= cfg_q[pick_idx].trig_lvl;
    end
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int N_PINS = 24,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              msg_valid,
  input logic              msg_ack,
  input logic              msg_level,
  input logic [IDX_W-1:0]  msg_pin,
  input logic [7:0]        msg_vector,
  input logic [N_PINS-1:0] pend_vec,
  input logic [N_PINS-1:0] rirr_vec
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !msg_valid);

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_pin) && $stable(msg_vector)));

  assert_pin_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (32'(msg_pin) < N_PINS));

  assert_drop_on_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ack) |=> !msg_valid);

  assert_presented_is_pending_R11: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> pend_vec[msg_pin]);

  assert_ack_clears_status_R11: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ack) |=> !pend_vec[$past(msg_pin)]);

  assert_no_redeliver_R8: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_level) |-> !rirr_vec[msg_pin]);

endmodule

bind irq_route_ctrl irq_route_chk #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_valid (msg_valid),
  .msg_ack   (msg_ack),
  .msg_level (msg_level),
  .msg_pin   (msg_pin),
  .msg_vector(msg_vector),
  .pend_vec  (pend_vec),
  .rirr_vec  (rirr_vec)
);

// File: tb/irq_route_ctrl_tb.sv
module irq_route_ctrl_tb;

  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_dest_logical, msg_level;
  logic [4:0]  msg_pin;
  logic [7:0]  msg_vector, msg_dest;
  logic        msg_ack = 1'b0;
  logic        eoi_valid = 1'b0;
  logic [7:0]  eoi_vector = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rst(rst), .irq_in(irq),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_pin(msg_pin), .msg_vector(msg_vector),
    .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical), .msg_level(msg_level),
    .msg_ack(msg_ack), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] wr;
    logic [31:0] exp;
  } regvec_t;

  localparam regvec_t REG_TAB [0:6] = '{
    '{8'h10, 32'h0001_2833, 32'h0001_2833},
    '{8'h11, 32'hA5FF_FFFF, 32'hA500_0000},
    '{8'h3E, 32'h0001_F0CC, 32'h0001_A0CC},
    '{8'h3F, 32'h1234_5678, 32'h1200_0000},
    '{8'h40, 32'hFFFF_FFFF, 32'h0000_0000},
    '{8'h0F, 32'hFFFF_FFFF, 32'h0000_0000},
    '{8'h14, 32'h0000_0700, 32'h0000_0000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic ack();
    msg_ack = 1'b1;
    tick();
    msg_ack = 1'b0;
  endtask

  task automatic eoi(input logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick();
    eoi_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset state
    chk("R1 msg_valid after reset", 32'(msg_valid), 0);
    for (int i = 0; i < N; i++) begin
      rd(8'(16 + 2 * i), d);
      chk("R1 low word reset", d, 32'h0001_0000);
      rd(8'(17 + 2 * i), d);
      chk("R1 high word reset", d, 32'h0);
    end

    // R2 R3: register table
    for (int k = 0; k < 7; k++) begin
      wr(REG_TAB[k].addr, REG_TAB[k].wr);
      rd(REG_TAB[k].addr, d);
      chk("R2 R3 register readback", d, REG_TAB[k].exp);
    end

    // R4 R6 R10 R11: edge pin 3
    wr(8'h16, 32'h0000_0041);
    wr(8'h17, 32'h2500_0000);
    irq[3] = 1'b1;
    tick();
    chk("R4 not yet valid", 32'(msg_valid), 0);
    tick();
    chk("R4 valid", 32'(msg_valid), 1);
    chk("R4 pin", 32'(msg_pin), 3);
    chk("R4 vector", 32'(msg_vector), 32'h41);
    chk("R4 dest", 32'(msg_dest), 32'h25);
    chk("R4 level flag", 32'(msg_level), 0);
    chk("R4 dest mode", 32'(msg_dest_logical), 0);
    irq[3] = 1'b0; tick();
    irq[3] = 1'b1; tick();
    chk("R10 still presented", 32'(msg_valid), 1);
    rd(8'h16, d);
    chk("R11 status pending", d, 32'h0000_1041);
    ack();
    chk("R11 valid drops at ack", 32'(msg_valid), 0);
    tick();
    chk("R6 no second message", 32'(msg_valid), 0);
    tick();
    chk("R6 still none", 32'(msg_valid), 0);
    rd(8'h16, d);
    chk("R11 status idle", d, 32'h0000_0041);

    // R5: active-low pin 5
    irq[5] = 1'b1;
    tick(); tick();
    wr(8'h1A, 32'h0000_2055);
    wr(8'h1B, 32'h0A00_0000);
    tick();
    chk("R5 inactive high", 32'(msg_valid), 0);
    irq[5] = 1'b0;
    tick(); tick();
    chk("R5 valid on fall", 32'(msg_valid), 1);
    chk("R5 pin", 32'(msg_pin), 5);
    chk("R5 vector", 32'(msg_vector), 32'h55);
    chk("R5 dest", 32'(msg_dest), 32'h0A);
    ack();
    irq[5] = 1'b1;
    tick(); tick(); tick();
    chk("R5 rise ignored", 32'(msg_valid), 0);

    // R10: priority between pins 1 and 2
    wr(8'h12, 32'h0000_0011);
    wr(8'h14, 32'h0000_0022);
    irq[1] = 1'b1; irq[2] = 1'b1;
    tick(); tick();
    chk("R10 lowest first", 32'(msg_pin), 1);
    chk("R10 vector first", 32'(msg_vector), 32'h11);
    tick(); tick();
    chk("R10 held valid", 32'(msg_valid), 1);
    chk("R10 held pin", 32'(msg_pin), 1);
    ack();
    chk("R11 gap after ack", 32'(msg_valid), 0);
    tick();
    chk("R10 second valid", 32'(msg_valid), 1);
    chk("R10 second pin", 32'(msg_pin), 2);
    chk("R10 second vector", 32'(msg_vector), 32'h22);
    ack();

    // R7: masking a waiting pin drops it
    irq[1] = 1'b0; irq[2] = 1'b0;
    tick();
    irq[1] = 1'b1; irq[2] = 1'b1;
    tick(); tick();
    chk("R7 pin1 presented", 32'(msg_pin), 1);
    wr(8'h14, 32'h0001_0022);
    ack();
    tick();
    chk("R7 masked pin dropped", 32'(msg_valid), 0);
    tick();
    chk("R7 still dropped", 32'(msg_valid), 0);
    rd(8'h14, d);
    chk("R7 status cleared", d, 32'h0001_0022);

    // R7: pin 7 masked since reset
    irq[7] = 1'b1;
    tick(); tick(); tick();
    chk("R7 masked pin silent", 32'(msg_valid), 0);
    rd(8'h1E, d);
    chk("R7 masked entry idle", d, 32'h0001_0000);

    // R8 R9: level pin 9, logical destination
    wr(8'h22, 32'h0000_8890);
    wr(8'h23, 32'h0300_0000);
    irq[9] = 1'b1;
    tick(); tick();
    chk("R8 level valid", 32'(msg_valid), 1);
    chk("R8 pin", 32'(msg_pin), 9);
    chk("R8 level flag", 32'(msg_level), 1);
    chk("R2 dest mode in message", 32'(msg_dest_logical), 1);
    chk("R8 dest", 32'(msg_dest), 32'h03);
    ack();
    rd(8'h22, d);
    chk("R8 remote flag set", d, 32'h0000_C890);
    tick(); tick();
    chk("R8 no redelivery", 32'(msg_valid), 0);
    eoi(8'h91);
    tick();
    chk("R9 foreign eoi ignored", 32'(msg_valid), 0);
    rd(8'h22, d);
    chk("R9 flag kept", d, 32'h0000_C890);
    eoi(8'h90);
    tick();
    chk("R9 not yet redelivered", 32'(msg_valid), 0);
    tick();
    chk("R9 redelivered", 32'(msg_valid), 1);
    chk("R9 redelivered pin", 32'(msg_pin), 9);
    ack();
    irq[9] = 1'b0;
    eoi(8'h90);
    tick(); tick();
    chk("R9 deasserted no message", 32'(msg_valid), 0);
    rd(8'h22, d);
    chk("R9 flag cleared", d, 32'h0000_8890);

    finish_run();
  end

endmodule